// File: doc/BRIEF.md
# Five-Level Multicarrier PWM Gate Generator

This block drives the eight switches of one phase leg of a five-level cascaded H-bridge inverter. The leg is two series cells, and each cell gives +Vdc, 0 or -Vdc, so the leg spans -2Vdc to +2Vdc. A signed digital reference sample is compared against four triangular carriers. Each carrier is a separate up/down counter, and every comparison result drives one leg of one cell through a fixed mapping. As a result, the number of comparisons that are true, minus two, equals the phase level.

A two-bit mode input selects how the four carriers are laid out. Three modes are level-shifted: the carriers sit in four stacked bands, either all in phase, with the upper pair opposed to the lower pair, or with each band opposed to its neighbour. The fourth mode is phase-shifted: all four carriers span the whole reference range, spaced a quarter period apart. The carrier half-period is a run-time input. The integrator sets it so that the carrier frequency is 40 times the reference frequency. A reference amplitude between 0.6 and 1.0 of twice the half-period covers the usual modulation-index range. The sine source, dead-time insertion and the other two phases live outside this block.

Top module: `mcpwm_gate_gen`

## Requirements
- R1: While `rst_n` is low, all carrier counts are 0 and rising, the latched reference is 0 and the layout is stacked. With `period_i`=8 this gives `cmp_o`=4'b0011 and `gate_o`=8'b10101010.
- R2: Each carrier count moves by one per clock between 0 and P=`period_i`, reverses at both ends, and has a period of 2P clocks. With P=0, all counts stay at 0. The first clock edge after reset, and every edge where `mode_i` differs from the layout in use, loads the start values given in R3, R4, R5 and R6 and adopts the new layout.
- R3: `mode_i`=0 is the stacked in-phase layout. Carrier k (k=0..3, bottom to top) has the value k*P + count. All four start at 0, rising.
- R4: `mode_i`=1 is the opposed-pair layout, with stacked values as in R3. Carriers 0 and 1 start at P, falling. Carriers 2 and 3 start at 0, rising.
- R5: `mode_i`=2 is the alternating layout, with stacked values as in R3. Carriers 1 and 3 start at P, falling. Carriers 0 and 2 start at 0, rising.
- R6: `mode_i`=3 is the shifted layout. Carrier k has the value 4*count. Carrier 0 starts at 0 rising, carrier 1 at P/2 rising, carrier 2 at P falling, and carrier 3 at P/2 falling (P/2 rounds down).
- R7: `cmp_o[k]` is 1 exactly when latched reference + 2P is strictly greater than the value of carrier k. A tie gives 0.
- R8: The latched reference takes `ref_i` on a load edge. It also takes `ref_i` on an edge where the count of carrier 0 is 0 or P before the edge. On any other edge, `ref_i` is ignored.
- R9: Each cell has a left leg L and a right leg R. In stacked layouts: cell A has L=`cmp_o[3]`, R=~`cmp_o[0]`; cell B has L=`cmp_o[2]`, R=~`cmp_o[1]`. In the shifted layout: cell A has L=`cmp_o[0]`, R=~`cmp_o[2]`; cell B has L=`cmp_o[1]`, R=~`cmp_o[3]`. The gate bits are `gate_o`[0..3] = A.L, ~A.L, A.R, ~A.R and `gate_o`[4..7] = B.L, ~B.L, B.R, ~B.R.
- R10: The phase level (gate[0]-gate[2])+(gate[4]-gate[6]) equals the number of set `cmp_o` bits minus 2.
- R11: A mode change in the middle of a run restarts all four carriers from the start values of the new layout on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Carrier layout select (0 stacked, 1 opposed pairs, 2 alternating, 3 shifted) |
| ref_i | input | RW (14) | Signed reference sample, full scale ±2P |
| period_i | input | CW (12) | Carrier half-period P in clocks, also the band height |
| cmp_o | output | 4 | Comparator results, bit k for carrier k |
| gate_o | output | 8 | Switch gates of both cells, complementary per leg |

## Verification
Two events can fall on the same edge: a reload caused by a mode change, and the reference latch that a carrier-0 turning point opens. Either event can also meet a change of `ref_i` that must be ignored. The vector table changes mode and reference at arbitrary points along the slope, including points where a turning point coincides with the change. A cycle-accurate phase model, built from the elapsed time since the last load, judges every cycle. Directed cases check a reference change in mid-slope that must stay invisible until the next turning point, and the exact comparator pattern on the first edge after a layout switch.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

  localparam int unsigned N_CARRIER = 4;

  typedef enum logic [1:0] {
    ARR_STACKED   = 2'd0,
    ARR_OPPOSED   = 2'd1,
    ARR_ALTERNATE = 2'd2,
    ARR_SHIFTED   = 2'd3
  } arr_mode_e;

  typedef enum logic [1:0] {
    SEED_LOW  = 2'd0,
    SEED_MID  = 2'd1,
    SEED_HIGH = 2'd2
  } seed_pt_e;

  typedef struct packed {
    seed_pt_e pt;
    logic     fall;
  } seed_t;

  // Start point and direction of carrier k for a given layout.
  function automatic seed_t carrier_seed(arr_mode_e m, int unsigned k);
    seed_t s;
    s.pt   = SEED_LOW;
    s.fall = 1'b0;
    unique case (m)
      ARR_STACKED: ;
      ARR_OPPOSED: begin
        if (k < 2) begin
          s.pt   = SEED_HIGH;
          s.fall = 1'b1;
        end
      end
      ARR_ALTERNATE: begin
        if (k % 2 == 1) begin
          s.pt   = SEED_HIGH;
          s.fall = 1'b1;
        end
      end
      ARR_SHIFTED: begin
        case (k)
          1:       begin s.pt = SEED_MID;  s.fall = 1'b0; end
          2:       begin s.pt = SEED_HIGH; s.fall = 1'b1; end
          3:       begin s.pt = SEED_MID;  s.fall = 1'b1; end
          default: begin s.pt = SEED_LOW;  s.fall = 1'b0; end
        endcase
      end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mcpwm_carrier.sv
module mcpwm_carrier
  import mcpwm_pkg::*;
#(
  parameter int unsigned CW  = 12,
  parameter int unsigned IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  arr_mode_e     mode_i,
  input  logic [CW-1:0] top_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fall_q, fall_d;
  seed_t         seed;

  assign seed = carrier_seed(mode_i, IDX);

  always_comb begin
    cnt_d  = cnt_q;
    fall_d = fall_q;
    if (load_i) begin
      fall_d = seed.fall;
      unique case (seed.pt)
        SEED_MID:  cnt_d = top_i >> 1;
        SEED_HIGH: cnt_d = top_i;
        default:   cnt_d = '0;
      endcase
    end else if (top_i == '0) begin
      cnt_d  = '0;
      fall_d = 1'b0;
    end else if (!fall_q) begin
      if (cnt_q >= top_i) begin
        cnt_d  = cnt_q - 1'b1;
        fall_d = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        cnt_d  = cnt_q + 1'b1;
        fall_d = 1'b0;
      end else begin
        cnt_d  = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fall_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fall_q <= fall_d;
    end
  end

  assign cnt_o = cnt_q;

  // R2: outside a load, a live carrier moves by exactly one count per clock
  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && top_i != '0) |=>
      (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mcpwm_compare.sv
module mcpwm_compare
  import mcpwm_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned RW = CW + 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  arr_mode_e                       mode_i,
  input  logic [CW-1:0]                   top_i,
  input  logic signed [RW-1:0]            ref_i,
  input  logic [N_CARRIER-1:0][CW-1:0]    cnt_i,
  output logic [N_CARRIER-1:0]            cmp_o
);

  localparam int unsigned XW = CW + 4;

  logic signed [XW-1:0] topx;
  logic signed [XW-1:0] ref_ext;
  logic signed [XW-1:0] ref_lift;

  assign topx     = $signed({4'b0000, top_i});
  assign ref_ext  = XW'(ref_i);
  assign ref_lift = ref_ext + (topx <<< 1);

  for (genvar k = 0; k < N_CARRIER; k++) begin : g_cmp
    localparam logic signed [XW-1:0] KX = XW'(k);
    logic signed [XW-1:0] cntx;
    logic signed [XW-1:0] carrier_val;
    assign cntx = $signed({4'b0000, cnt_i[k]});
    always_comb begin
      if (mode_i == ARR_SHIFTED) carrier_val = cntx <<< 2;
      else                       carrier_val = topx * KX + cntx;
    end
    assign cmp_o[k] = (ref_lift > carrier_val);
  end

  // R7: stacked bands never overlap, so the results form a thermometer code
  a_r7_stacked_thermo: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != ARR_SHIFTED && cnt_i[0] <= top_i && cnt_i[1] <= top_i &&
     cnt_i[2] <= top_i && cnt_i[3] <= top_i) |->
      ((cmp_o[3:1] & ~cmp_o[2:0]) == 3'b000));

  // R3: in the stacked in-phase layout all carriers move together
  a_r3_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == ARR_STACKED) |->
      (cnt_i[0] == cnt_i[1] && cnt_i[1] == cnt_i[2] && cnt_i[2] == cnt_i[3]));

endmodule

// File: rtl/mcpwm_gate_map.sv
module mcpwm_gate_map
  import mcpwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  arr_mode_e            mode_i,
  input  logic [N_CARRIER-1:0] cmp_i,
  output logic [7:0]           gate_o
);

  logic shifted;
  assign shifted = (mode_i == ARR_SHIFTED);

  for (genvar c = 0; c < 2; c++) begin : g_cell
    logic left_up, right_up;
    assign left_up  = shifted ? cmp_i[c]     : cmp_i[3-c];
    assign right_up = ~(shifted ? cmp_i[c+2] : cmp_i[c]);
    assign gate_o[4*c+0] = left_up;
    assign gate_o[4*c+1] = ~left_up;
    assign gate_o[4*c+2] = right_up;
    assign gate_o[4*c+3] = ~right_up;
  end

  // R10: synthesized phase level tracks the count of true comparisons
  a_r10_level: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gate_o[0]) - int'(gate_o[2]) + int'(gate_o[4]) - int'(gate_o[6]))
      == ($countones(cmp_i) - 2));

endmodule

// File: rtl/mcpwm_gate_gen.sv
module mcpwm_gate_gen
  import mcpwm_pkg::*;
#(
  parameter int unsigned CW = 12,
  parameter int unsigned RW = CW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_i,
  input  logic signed [RW-1:0] ref_i,
  input  logic [CW-1:0]        period_i,
  output logic [3:0]           cmp_o,
  output logic [7:0]           gate_o
);

  arr_mode_e                     mode_q, mode_d, mode_in;
  logic                          init_q;
  logic                          load;
  logic                          turn0;
  logic                          ref_en;
  logic signed [RW-1:0]          ref_q, ref_d;
  logic [N_CARRIER-1:0][CW-1:0]  cnt;

  assign mode_in = arr_mode_e'(mode_i);
  assign load    = init_q | (mode_in != mode_q);
  assign turn0   = (cnt[0] == '0) || (cnt[0] == period_i);
  assign ref_en  = load | turn0;

  always_comb begin
    mode_d = load   ? mode_in : mode_q;
    ref_d  = ref_en ? ref_i   : ref_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ARR_STACKED;
      init_q <= 1'b1;
      ref_q  <= '0;
    end else begin
      mode_q <= mode_d;
      init_q <= 1'b0;
      ref_q  <= ref_d;
    end
  end

  for (genvar k = 0; k < N_CARRIER; k++) begin : g_car
    mcpwm_carrier #(.CW(CW), .IDX(k)) u_car (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .mode_i (mode_in),
      .top_i  (period_i),
      .cnt_o  (cnt[k])
    );
  end

  mcpwm_compare #(.CW(CW), .RW(RW)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_q),
    .top_i  (period_i),
    .ref_i  (ref_q),
    .cnt_i  (cnt),
    .cmp_o  (cmp_o)
  );

  mcpwm_gate_map u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_q),
    .cmp_i  (cmp_o),
    .gate_o (gate_o)
  );

  // R8: the latched reference only moves on a load or a carrier-0 turning point
  a_r8_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !turn0) |=> $stable(ref_q));

  // R11: a mode change is adopted on the very next edge
  a_r11_adopt: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in != mode_q) |=> (mode_q == $past(mode_in)));

endmodule

// File: tb/mcpwm_gate_gen_test.sv
module mcpwm_gate_gen_test;

  localparam int CW = 12;
  localparam int RW = 14;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [1:0]           mode;
  logic signed [RW-1:0] refv;
  logic [CW-1:0]        period;
  logic [3:0]           cmp;
  logic [7:0]           gate;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mcpwm_gate_gen #(.CW(CW), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ref_i(refv),
    .period_i(period), .cmp_o(cmp), .gate_o(gate)
  );

  // Phase model: carrier values follow from time elapsed since the last load.
  int   m_t;
  int   m_ref;
  int   m_mode;
  bit   m_init;

  function automatic int tri_at(int p, int tp);
    int q;
    if (tp == 0) return 0;
    q = p % (2 * tp);
    return (q <= tp) ? q : 2 * tp - q;
  endfunction

  function automatic int offs(int md, int k, int tp);
    case (md)
      1:       return (k < 2) ? tp : 0;
      2:       return (k % 2 == 1) ? tp : 0;
      3:       return (k == 0) ? 0 : (k == 1) ? tp / 2 : (k == 2) ? tp : 3 * tp / 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] exp_cmp();
    logic [3:0] e;
    int tp;
    tp = int'(period);
    for (int k = 0; k < 4; k++) begin
      int c, v;
      c = tri_at(offs(m_mode, k, tp) + m_t, tp);
      v = (m_mode == 3) ? 4 * c : k * tp + c;
      e[k] = (m_ref + 2 * tp) > v;
    end
    return e;
  endfunction

  function automatic logic [7:0] exp_gate(logic [3:0] c, int md);
    logic al, ar, bl, br;
    al = (md == 3) ? c[0] : c[3];
    ar = ~((md == 3) ? c[2] : c[0]);
    bl = (md == 3) ? c[1] : c[2];
    br = ~((md == 3) ? c[3] : c[1]);
    return {~br, br, ~bl, bl, ~ar, ar, ~al, al};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_init = 1'b1; m_mode = 0; m_t = 0; m_ref = 0;
    end else if (m_init || int'(mode) != m_mode) begin
      m_mode = int'(mode); m_t = 0; m_ref = int'(refv); m_init = 1'b0;
    end else begin
      int c0;
      c0 = tri_at(offs(m_mode, 0, int'(period)) + m_t, int'(period));
      if (c0 == 0 || c0 == int'(period)) m_ref = int'(refv);
      m_t = m_t + 1;
    end
  end

  task automatic chk4(string tag, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s cmp got=%b exp=%b t=%0d", tag, got, exp, m_t);
    end
  endtask

  task automatic chk8(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s gate got=%b exp=%b t=%0d", tag, got, exp, m_t);
    end
  endtask

  task automatic chk_int(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic string mode_tag();
    if (period == '0) return "R2";
    case (m_mode)
      1:       return "R4";
      2:       return "R5";
      3:       return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check_model();
    logic [3:0] e;
    e = exp_cmp();
    chk4({"R7 ", mode_tag()}, cmp, e);
    chk8("R9", gate, exp_gate(e, m_mode));
    chk_int("R10 level", int'(gate[0]) - int'(gate[2]) + int'(gate[4]) - int'(gate[6]),
            $countones(e) - 2);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {rst, mode, period, ref, cycles}
  localparam int NV = 16;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 2'd0, 12'd8,    14'sd0,     10'd40},
    {1'b0, 2'd0, 12'd8,    14'sd10,    10'd37},
    {1'b0, 2'd0, 12'd8,    -14'sd9,    10'd3},
    {1'b0, 2'd1, 12'd8,    -14'sd5,    10'd40},
    {1'b0, 2'd1, 12'd8,    14'sd13,    10'd29},
    {1'b0, 2'd2, 12'd8,    14'sd3,     10'd40},
    {1'b0, 2'd2, 12'd8,    -14'sd16,   10'd20},
    {1'b0, 2'd3, 12'd8,    14'sd16,    10'd20},
    {1'b0, 2'd3, 12'd8,    -14'sd7,    10'd41},
    {1'b0, 2'd0, 12'd8,    14'sd8,     10'd11},
    {1'b1, 2'd3, 12'd100,  14'sd77,    10'd300},
    {1'b0, 2'd0, 12'd100,  -14'sd150,  10'd200},
    {1'b1, 2'd2, 12'd0,    14'sd1,     10'd5},
    {1'b0, 2'd2, 12'd0,    14'sd0,     10'd5},
    {1'b1, 2'd1, 12'd4094, 14'sd8188,  10'd200},
    {1'b0, 2'd2, 12'd4094, -14'sd8188, 10'd150}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    mode   = 2'd0;
    refv   = '0;
    period = 12'd8;
    repeat (2) @(negedge clk);

    // R1: reset state
    chk4("R1", cmp, 4'b0011);
    chk8("R1", gate, 8'b10101010);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][38]) begin
        rst_n  = 1'b0;
        period = VEC[i][35:24];
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
      end
      mode = VEC[i][37:36];
      refv = $signed(VEC[i][23:10]);
      for (int n = 0; n < int'(VEC[i][9:0]); n++) begin
        step();
        check_model();
      end
    end

    // R8: mid-slope reference change stays invisible until a turning point
    rst_n = 1'b0; period = 12'd8; mode = 2'd0; refv = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step();
    step();
    refv = 14'sd16;
    step();
    chk4("R8 ignored mid-slope", cmp, 4'b0011);
    repeat (7) step();
    chk4("R8 taken at peak", cmp, 4'b1111);

    // R11: layout switch restarts carriers on the next edge
    mode = 2'd3; refv = '0;
    repeat (3) step();
    mode = 2'd3;
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    mode = 2'd0;
    repeat (5) step();
    mode = 2'd3;
    step();
    chk4("R11 shifted seed", cmp, 4'b0001);
    chk8("R11 shifted gates", gate, 8'b01100101);

    // R1: asynchronous reset mid-run
    period = 12'd8;
    rst_n = 1'b0;
    #1;
    chk4("R1 async", cmp, 4'b0011);
    chk8("R1 async", gate, 8'b10101010);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule